// File: doc/BRIEF.md
# LFSR Raster Timing Generator

This block produces the horizontal sync, vertical sync, display-enable and frame-start signals for a raster display. It runs from the pixel clock. Its two position counters are 16-bit linear feedback shift registers rather than binary counters, so no carry chain limits the pixel rate. Each counter state stands for a step count from the seed. Every programmed timing point is therefore the LFSR state that the counter reaches after the wanted number of steps, and never the plain binary number. Software computes these states; the block only compares against them.

The horizontal counter steps once per clock. The vertical counter steps once per line. On each axis, one set/clear window forms the sync pulse and a second forms the active video region. A two-bit blank control can blank the video or power down all display outputs. The frame timing keeps running in every blank mode. The programmed values are meant to be held stable while the block runs, and are changed under reset.

Top module: `lfsr_raster_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, hsync_o, vsync_o, de_o and frame_start_o are all low. Both counters sit at the seed state 0xFFFF, which is step count 0.
- R2: One counter step shifts the state left by one bit and inserts, as the new bit 0, the XOR of old bits 15, 4, 2 and 1. Every timing input holds the state reached after N such steps from 0xFFFF, where N is the binary count meant. For example, N=1 is 0xFFFE and N=2 is 0xFFFC.
- R3: The horizontal count goes up by one each clock. In the clock after the count equals the state programmed on h_end_i, the count returns to 0. A line with end count E therefore lasts E+1 clocks.
- R4: The vertical count goes up by one on the clock that ends each line. After a line whose vertical count equals v_end_i, it returns to 0. A frame with vertical end count V therefore lasts V+1 lines.
- R5: hsync_o is active high. With on count S and off count E (S < E, and E no greater than the line end count), it is high exactly in the cycles whose horizontal count lies in S+1 through E.
- R6: vsync_o is active high. It is high exactly on the lines whose vertical count lies in S+1 through E, where S and E are the vertical sync on and off counts.
- R7: de_o is high exactly when the horizontal count lies in the horizontal video window (on+1 through off) and the vertical count lies in the vertical video window (on+1 through off).
- R8: frame_start_o is high for exactly one cycle: the first cycle of every frame after the first, where the horizontal and vertical counts are both 0. It stays low for the frame that follows reset.
- R9: blank_mode_i takes effect in the same cycle and never disturbs the counters or frame_start_o. 2'b00 is normal operation. 2'b01 blanks the video, forcing de_o low while both syncs keep running. 2'b10 and 2'b11 are powerdown, forcing hsync_o, vsync_o and de_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_end_i | input | 16 | LFSR state of the last horizontal count of a line |
| h_sync_on_i | input | 16 | LFSR state of the horizontal sync on count |
| h_sync_off_i | input | 16 | LFSR state of the horizontal sync off count |
| h_video_on_i | input | 16 | LFSR state of the horizontal video on count |
| h_video_off_i | input | 16 | LFSR state of the horizontal video off count |
| v_end_i | input | 16 | LFSR state of the last vertical count of a frame |
| v_sync_on_i | input | 16 | LFSR state of the vertical sync on count |
| v_sync_off_i | input | 16 | LFSR state of the vertical sync off count |
| v_video_on_i | input | 16 | LFSR state of the vertical video on count |
| v_video_off_i | input | 16 | LFSR state of the vertical video off count |
| blank_mode_i | input | 2 | 00 normal, 01 video blanked, 1x powerdown |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable |
| frame_start_o | output | 1 | One-cycle pulse at the start of each frame |

## Verification
Each window flag is registered one edge after the counter matches its on or off state. The window outputs are therefore due in the cycle that follows the matching count, which is why the requirements state the windows as on+1 through off. The bench keeps binary horizontal and vertical counts that advance in step with the clock edges. Just after each falling edge it compares all four outputs against the windows evaluated at the current counts. frame_start_o is due in the first cycle of the frame, one edge after the reload, and its spacing is checked against the frame length in clocks. blank_mode_i acts through gating alone, so the bench drives it after a falling edge and checks the gated outputs in that same cycle.

// File: rtl/lfsr_vtg_pkg.sv
package lfsr_vtg_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
  localparam int unsigned NUM_WIN = 2;  // 0: sync, 1: video
  localparam int unsigned WIN_SYNC = 0;
  localparam int unsigned WIN_VIDEO = 1;
  localparam logic [1:0] BLANK_ON = 2'b00;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction
endpackage

// File: rtl/lfsr_pos_counter.sv
module lfsr_pos_counter
  import lfsr_vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [LFSR_W-1:0] end_state_i,
  output logic [LFSR_W-1:0] state_o,
  output logic              wrap_o
);
  logic [LFSR_W-1:0] state_q;

  assign wrap_o  = adv_i && (state_q == end_state_i);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= LFSR_SEED;
    else if (adv_i)  state_q <= wrap_o ? LFSR_SEED : lfsr_next(state_q);
  end

  // the all-zero state is a lock-up state the sequence never reaches
  assert_no_lockup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);

  assert_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (state_o == LFSR_SEED));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(state_o));
endmodule

// File: rtl/lfsr_window.sv
module lfsr_window
  import lfsr_vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [LFSR_W-1:0] state_i,
  input  logic [LFSR_W-1:0] on_i,
  input  logic [LFSR_W-1:0] off_i,
  output logic              active_o
);
  logic active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else if (upd_i) begin
      if (state_i == on_i)       active_q <= 1'b1;
      else if (state_i == off_i) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

  // covers the sync and video windows of both axes (R5, R6, R7)
  assert_window_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && (state_i == on_i) |=> active_o);

  assert_window_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && (state_i == off_i) && (state_i != on_i) |=> !active_o);
endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
  import lfsr_vtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LFSR_W-1:0] h_end_i,
  input  logic [LFSR_W-1:0] h_sync_on_i,
  input  logic [LFSR_W-1:0] h_sync_off_i,
  input  logic [LFSR_W-1:0] h_video_on_i,
  input  logic [LFSR_W-1:0] h_video_off_i,
  input  logic [LFSR_W-1:0] v_end_i,
  input  logic [LFSR_W-1:0] v_sync_on_i,
  input  logic [LFSR_W-1:0] v_sync_off_i,
  input  logic [LFSR_W-1:0] v_video_on_i,
  input  logic [LFSR_W-1:0] v_video_off_i,
  input  logic [1:0]        blank_mode_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              frame_start_o
);
  logic [LFSR_W-1:0] h_state, v_state;
  logic              h_wrap, v_wrap;
  logic [LFSR_W-1:0] h_on [NUM_WIN];
  logic [LFSR_W-1:0] h_off[NUM_WIN];
  logic [LFSR_W-1:0] v_on [NUM_WIN];
  logic [LFSR_W-1:0] v_off[NUM_WIN];
  logic [NUM_WIN-1:0] h_act, v_act;
  logic              fs_q;
  logic              pwr_down, vid_off;

  assign h_on[WIN_SYNC]   = h_sync_on_i;
  assign h_off[WIN_SYNC]  = h_sync_off_i;
  assign h_on[WIN_VIDEO]  = h_video_on_i;
  assign h_off[WIN_VIDEO] = h_video_off_i;
  assign v_on[WIN_SYNC]   = v_sync_on_i;
  assign v_off[WIN_SYNC]  = v_sync_off_i;
  assign v_on[WIN_VIDEO]  = v_video_on_i;
  assign v_off[WIN_VIDEO] = v_video_off_i;

  lfsr_pos_counter u_h_cnt (
    .clk_i, .rst_ni, .adv_i(1'b1), .end_state_i(h_end_i),
    .state_o(h_state), .wrap_o(h_wrap)
  );

  lfsr_pos_counter u_v_cnt (
    .clk_i, .rst_ni, .adv_i(h_wrap), .end_state_i(v_end_i),
    .state_o(v_state), .wrap_o(v_wrap)
  );

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    lfsr_window u_h_win (
      .clk_i, .rst_ni, .upd_i(1'b1), .state_i(h_state),
      .on_i(h_on[gi]), .off_i(h_off[gi]), .active_o(h_act[gi])
    );
    // vertical windows move only on line boundaries
    lfsr_window u_v_win (
      .clk_i, .rst_ni, .upd_i(h_wrap), .state_i(v_state),
      .on_i(v_on[gi]), .off_i(v_off[gi]), .active_o(v_act[gi])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fs_q <= 1'b0;
    else         fs_q <= v_wrap;
  end

  assign pwr_down      = blank_mode_i[1];
  assign vid_off       = (blank_mode_i != BLANK_ON);
  assign hsync_o       = h_act[WIN_SYNC] & ~pwr_down;
  assign vsync_o       = v_act[WIN_SYNC] & ~pwr_down;
  assign de_o          = h_act[WIN_VIDEO] & v_act[WIN_VIDEO] & ~vid_off;
  assign frame_start_o = fs_q;

  assert_pd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_mode_i[1] |-> !hsync_o && !vsync_o && !de_o);

  assert_de_needs_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (blank_mode_i == BLANK_ON));

  assert_fs_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (h_state == LFSR_SEED) && (v_state == LFSR_SEED));

  assert_fs_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o && (h_end_i != LFSR_SEED) |=> !frame_start_o);
endmodule

// File: tb/test_lfsr_raster_timer.sv
module test_lfsr_raster_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] h_end_i = '1, h_sync_on_i = '1, h_sync_off_i = '1, h_video_on_i = '1, h_video_off_i = '1;
  logic [15:0] v_end_i = '1, v_sync_on_i = '1, v_sync_off_i = '1, v_video_on_i = '1, v_video_off_i = '1;
  logic [1:0]  blank_mode_i = 2'b00;
  logic        hsync_o, vsync_o, de_o, frame_start_o;

  int tests = 0, fails = 0;
  int ht, hss, hse, hds, hde, vt, vss, vse, vds, vde;
  int hc, vc, cyc, last_fs;
  bit fs_exp, done = 0;

  lfsr_raster_timer i_lfsr_raster_timer (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [15:0] lfsr_ref(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int k = 0; k < n; k++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  function automatic bit in_win(input int c, input int s, input int e);
    return (c >= s + 1) && (c <= e);
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s hc=%0d vc=%0d mode=%0d actual=%0b expected=%0b",
               tag, hc, vc, blank_mode_i, act, exp);
    end
  endtask

  task automatic program_mode();
    h_end_i = lfsr_ref(ht - 1);
    h_sync_on_i = lfsr_ref(hss);  h_sync_off_i = lfsr_ref(hse);
    h_video_on_i = lfsr_ref(hds); h_video_off_i = lfsr_ref(hde);
    v_end_i = lfsr_ref(vt);
    v_sync_on_i = lfsr_ref(vss);  v_sync_off_i = lfsr_ref(vse);
    v_video_on_i = lfsr_ref(vds); v_video_off_i = lfsr_ref(vde);
  endtask

  task automatic check_cycle();
    bit pd, off;
    pd  = blank_mode_i[1];
    off = (blank_mode_i != 2'b00);
    chk(hsync_o, in_win(hc, hss, hse) && !pd, pd ? "R9 hsync" : "R5 hsync");
    chk(vsync_o, in_win(vc, vss, vse) && !pd, pd ? "R9 vsync" : "R6 vsync");
    chk(de_o, in_win(hc, hds, hde) && in_win(vc, vds, vde) && !off, off ? "R9 de" : "R7 de");
    chk(frame_start_o, fs_exp, "R8 frame_start");
    if (frame_start_o === 1'b1) begin
      tests++;
      if (cyc - last_fs != ht * (vt + 1)) begin
        fails++;
        $display("FAIL R3 R4 frame length actual=%0d expected=%0d", cyc - last_fs, ht * (vt + 1));
      end
      last_fs = cyc;
    end
  endtask

  task automatic step_model();
    fs_exp = 0;
    if (hc == ht - 1) begin
      hc = 0;
      if (vc == vt) begin vc = 0; fs_exp = 1; end
      else vc++;
    end else hc++;
    cyc++;
  endtask

  // blank_sel: -1 random changes, otherwise held at that value
  task automatic run_mode(input int frames, input int blank_sel);
    @(negedge clk_i);
    rst_ni = 1'b0;
    program_mode();
    blank_mode_i = 2'b00;
    @(negedge clk_i);
    chk(hsync_o, 1'b0, "R1 hsync"); chk(vsync_o, 1'b0, "R1 vsync");
    chk(de_o, 1'b0, "R1 de");       chk(frame_start_o, 1'b0, "R1 frame_start");
    rst_ni = 1'b1;
    hc = 0; vc = 0; cyc = 0; last_fs = 0; fs_exp = 0;
    if (blank_sel >= 0) blank_mode_i = 2'(blank_sel);
    #1;
    check_cycle();
    step_model();
    for (int n = 1; n < frames * ht * (vt + 1) + 3; n++) begin
      @(negedge clk_i);
      if (blank_sel < 0 && ($urandom % 16) == 0) blank_mode_i = 2'($urandom % 4);
      #1;
      check_cycle();
      step_model();
    end
  endtask

  task automatic rand_mode();
    ht  = 16 + int'($urandom % 25);
    hss = 1;
    hse = 2 + int'($urandom % 4);
    hds = hse + 1 + int'($urandom % 3);
    hde = hds + 2 + int'($urandom % (ht - hds - 3));
    vt  = 6 + int'($urandom % 10);
    vss = 0;
    vse = 1 + int'($urandom % 2);
    vds = vse + int'($urandom % 2);
    vde = vds + 1 + int'($urandom % (vt - vds));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R2: step function anchors
    tests++; if (lfsr_ref(1) !== 16'hFFFE) begin fails++; $display("FAIL R2 step1 actual=%h expected=fffe", lfsr_ref(1)); end
    tests++; if (lfsr_ref(2) !== 16'hFFFC) begin fails++; $display("FAIL R2 step2 actual=%h expected=fffc", lfsr_ref(2)); end

    // small mode: 20 clocks per line, 13 lines per frame
    ht = 20; hss = 1; hse = 3; hds = 6; hde = 18;
    vt = 12; vss = 0; vse = 2; vds = 3; vde = 11;
    run_mode(2, 0);
    run_mode(1, 1);   // video blanked, syncs run (R9)
    run_mode(1, 2);   // powerdown (R9)
    run_mode(1, 3);
    // video windows ending on the last count of each axis
    hde = ht - 1; vde = vt;
    run_mode(2, 0);
    for (int m = 0; m < 8; m++) begin
      rand_mode();
      run_mode(2, (m % 2 == 0) ? -1 : 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule